// File: doc/BRIEF.md
# Round-Robin Receive Channel Drainer

This block is the master side of a multi-channel receive link that carries 32-bit words out of four slave buffers. The slave gives no per-channel fill status that can be polled, so the controller visits the channels in a fixed rotation. For each visit it drives the channel address and an active-low read strobe. It then watches the data, start-of-packet and end-of-packet lines and a "word present" flag, which answer each read strobe two clock cycles later. Every word that comes back flagged present is forwarded on an output stream, tagged with the channel it came from.

A visit ends for one of two reasons. Either enough reads have been issued to fill the per-visit word budget, or a returned flag shows that the channel has run dry. In both cases the controller parks the strobe for one cycle, moves the address on the next cycle, and resumes reading on the cycle after that. Words still in flight from the channel being left are captured as they arrive. A single empty slot right after an end-of-packet word is the slave's normal gap between packets. The controller tolerates it and does not read it as a dry channel, even when that gap falls at the start of the next visit to that channel.

Top module: `rrx_master`

## Requirements
- R1: While `rst` (active-high, synchronous) is asserted, `phy_rd_n` is 1, `phy_addr` is 0 and `out_valid` is 0. The first visit after release is to channel 0.
- R2: Visits follow the channel order 0, 1, 2, 3, 0, … with no channel skipped.
- R3: No visit delivers more than 30 words. On a channel that always has data and sends no packet gaps, a visit holds `phy_rd_n` low for exactly 30 consecutive cycles.
- R4: A word is taken only in the cycle two clock cycles after a cycle in which `phy_rd_n` was low. `phy_avail` and `phy_data` in any other cycle have no effect on the output.
- R5: Between two visits, `phy_rd_n` is high for exactly two cycles. During the first of these cycles `phy_addr` still holds the old channel. In the second, `phy_addr` holds the next channel. `phy_rd_n` goes low again on the following cycle with the address unchanged.
- R6: A read that returns `phy_avail` = 0, when the previous return from that channel was not an end-of-packet word, marks the channel as dry. The strobe then goes high on the next cycle. A visit to a channel holding n < 27 words (no end-of-packet among them) lasts n + 3 strobe cycles and delivers n words.
- R7: Words that arrive after the strobe has gone high, answering reads issued before, are still forwarded with the old channel number.
- R8: One empty return straight after an end-of-packet word on the same channel is treated as a packet gap. It is not counted as a word and does not end the visit, including when the end-of-packet word came in the previous visit to that channel.
- R9: Each taken word appears on the output one cycle after its return, with `out_valid` = 1, the channel number on `out_chan`, and the data, start and end markers unchanged. Words of one channel come out in the order they were read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous reset, active high |
| phy_addr | output | 2 | Channel address presented to the slave |
| phy_rd_n | output | 1 | Read strobe, active low |
| phy_avail | input | 1 | Word-present flag, answering the strobe two cycles later |
| phy_data | input | 32 | Returned data word |
| phy_sop | input | 1 | Returned word starts a packet |
| phy_eop | input | 1 | Returned word ends a packet |
| out_valid | output | 1 | Output word valid |
| out_chan | output | 2 | Channel the output word was read from |
| out_data | output | 32 | Output data word |
| out_sop | output | 1 | Output word starts a packet |
| out_eop | output | 1 | Output word ends a packet |

## Verification
The hardest case to reach from the ports is a packet gap that straddles a visit boundary. The end-of-packet word has to be the last word of one visit, and the empty slot the very first return of the next visit to the same channel. The bench reaches it with a slave model that uses three-word packets and inserts one empty return after each end-of-packet word. Because the 30-word budget is a multiple of three, most visits end on a packet boundary, and the gap is forced into the start of the following visit. In that scenario, dry-channel visits of known length and unsolicited "present" pulses during the switch gap are also checked against per-visit strobe and word counts.

// File: rtl/rrx_pkg.sv
package rrx_pkg;

    localparam int RRX_NCH       = 4;
    localparam int RRX_CH_W      = $clog2(RRX_NCH);
    localparam int RRX_DW        = 32;
    localparam int RRX_BURST_MAX = 30;
    localparam int RRX_RESP_LAT  = 2;

    typedef logic [RRX_CH_W-1:0] chan_t;
    typedef logic [RRX_DW-1:0]   word_t;

    // Visit sequencing: read burst, strobe parked on old channel, new address presented
    typedef enum logic [1:0] {
        VISIT_READ   = 2'd0,
        VISIT_PARK   = 2'd1,
        VISIT_SWITCH = 2'd2
    } visit_state_e;

    typedef struct packed {
        logic  valid;
        chan_t chan;
        logic  sop;
        logic  eop;
        word_t data;
    } beat_t;

    function automatic chan_t next_chan(input chan_t c);
        chan_t n;
        if (c == chan_t'(RRX_NCH - 1)) begin
            n = '0;
        end else begin
            n = c + chan_t'(1);
        end
        return n;
    endfunction

endpackage

// File: rtl/rrx_issue_pipe.sv
module rrx_issue_pipe
    import rrx_pkg::*;
#(
    parameter int LAT   = RRX_RESP_LAT,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_en,
    input  chan_t            issue_chan,
    output logic             ret_en,
    output chan_t            ret_chan,
    output logic [CNT_W-1:0] inflight
);

    logic [LAT:1] en_sr;
    chan_t        ch_sr [LAT:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_sr <= '0;
            for (int i = 1; i <= LAT; i++) begin
                ch_sr[i] <= '0;
            end
        end else begin
            en_sr[1] <= issue_en;
            ch_sr[1] <= issue_chan;
            for (int i = LAT; i > 1; i--) begin
                en_sr[i] <= en_sr[i-1];
                ch_sr[i] <= ch_sr[i-1];
            end
        end
    end

    assign ret_en   = en_sr[LAT];
    assign ret_chan = ch_sr[LAT];

    // Reads issued but not yet answered, excluding the one answering now
    generate
        if (LAT == 1) begin : g_no_infl
            assign inflight = '0;
        end else begin : g_infl
            always_comb begin
                inflight = '0;
                for (int i = 1; i < LAT; i++) begin
                    inflight = inflight + CNT_W'(en_sr[i]);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rrx_visit_ctrl.sv
module rrx_visit_ctrl
    import rrx_pkg::*;
#(
    parameter int BURST_MAX = RRX_BURST_MAX,
    parameter int CNT_W     = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ret_en,
    input  chan_t            ret_chan,
    input  logic             rsp_avail,
    input  logic             rsp_eop,
    input  logic [CNT_W-1:0] inflight,
    output logic             rd_n,
    output chan_t            addr,
    output logic             take
);

    visit_state_e     state_q;
    chan_t            chan_q;
    logic             rd_n_q;
    logic [CNT_W-1:0] cnt_q;
    logic [RRX_NCH-1:0] gap_ok_q;   // per channel: last return was an end-of-packet word
    logic [RRX_NCH-1:0] ret_hit;

    logic             hole;
    logic             pkt_gap;
    logic             drained;
    logic [CNT_W-1:0] potential;
    logic             budget_hit;

    generate
        for (genvar g = 0; g < RRX_NCH; g++) begin : g_hit
            assign ret_hit[g] = ret_en && (ret_chan == chan_t'(g));
        end
    endgenerate

    assign take       = ret_en && rsp_avail;
    assign hole       = ret_en && !rsp_avail;
    assign pkt_gap    = hole && gap_ok_q[ret_chan];
    assign drained    = hole && !gap_ok_q[ret_chan];
    assign potential  = cnt_q + CNT_W'(take) + inflight + CNT_W'(1);
    assign budget_hit = potential >= CNT_W'(BURST_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= VISIT_SWITCH;
            chan_q  <= '0;
            rd_n_q  <= 1'b1;
        end else begin
            unique case (state_q)
                VISIT_READ: begin
                    if (drained || budget_hit) begin
                        state_q <= VISIT_PARK;
                        rd_n_q  <= 1'b1;
                    end else begin
                        rd_n_q  <= 1'b0;
                    end
                end
                VISIT_PARK: begin
                    state_q <= VISIT_SWITCH;
                    chan_q  <= next_chan(chan_q);
                    rd_n_q  <= 1'b1;
                end
                VISIT_SWITCH: begin
                    state_q <= VISIT_READ;
                    rd_n_q  <= 1'b0;
                end
                default: begin
                    state_q <= VISIT_SWITCH;
                    rd_n_q  <= 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || state_q == VISIT_SWITCH) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_ok_q <= '0;
        end else begin
            for (int c = 0; c < RRX_NCH; c++) begin
                if (ret_hit[c]) begin
                    gap_ok_q[c] <= take && rsp_eop;
                end
            end
        end
    end

    assign rd_n = rd_n_q;
    assign addr = chan_q;

    // R3: words taken in one visit never exceed the budget
    p_budget_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(BURST_MAX));

    // R6: a dry return during a burst releases the strobe on the next cycle
    p_drain_release_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == VISIT_READ && drained) |=> rd_n_q);

    // R8: a packet gap never ends the burst on its own
    p_gap_keeps_reading_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == VISIT_READ && pkt_gap && !budget_hit) |=> !rd_n_q);

endmodule

// File: rtl/rrx_capture.sv
module rrx_capture
    import rrx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  chan_t chan,
    input  word_t data,
    input  logic  sop,
    input  logic  eop,
    output beat_t beat
);

    beat_t beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q.valid <= 1'b0;
        end else begin
            beat_q.valid <= take;
        end
        beat_q.chan <= chan;
        beat_q.data <= data;
        beat_q.sop  <= sop;
        beat_q.eop  <= eop;
    end

    assign beat = beat_q;

endmodule

// File: rtl/rrx_master.sv
module rrx_master
    import rrx_pkg::*;
#(
    parameter int BURST_MAX = RRX_BURST_MAX,
    parameter int RESP_LAT  = RRX_RESP_LAT
) (
    input  logic                clk,
    input  logic                rst,
    output logic [RRX_CH_W-1:0] phy_addr,
    output logic                phy_rd_n,
    input  logic                phy_avail,
    input  logic [RRX_DW-1:0]   phy_data,
    input  logic                phy_sop,
    input  logic                phy_eop,
    output logic                out_valid,
    output logic [RRX_CH_W-1:0] out_chan,
    output logic [RRX_DW-1:0]   out_data,
    output logic                out_sop,
    output logic                out_eop
);

    localparam int CNT_W = $clog2(BURST_MAX + RESP_LAT + 2);

    logic             ret_en;
    chan_t            ret_chan;
    logic [CNT_W-1:0] inflight;
    logic             rd_n;
    chan_t            addr;
    logic             take;
    beat_t            beat;

    rrx_visit_ctrl #(
        .BURST_MAX (BURST_MAX),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ret_en    (ret_en),
        .ret_chan  (ret_chan),
        .rsp_avail (phy_avail),
        .rsp_eop   (phy_eop),
        .inflight  (inflight),
        .rd_n      (rd_n),
        .addr      (addr),
        .take      (take)
    );

    rrx_issue_pipe #(
        .LAT   (RESP_LAT),
        .CNT_W (CNT_W)
    ) u_pipe (
        .clk        (clk),
        .rst        (rst),
        .issue_en   (!rd_n),
        .issue_chan (addr),
        .ret_en     (ret_en),
        .ret_chan   (ret_chan),
        .inflight   (inflight)
    );

    rrx_capture u_cap (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .chan (ret_chan),
        .data (phy_data),
        .sop  (phy_sop),
        .eop  (phy_eop),
        .beat (beat)
    );

    assign phy_rd_n  = rd_n;
    assign phy_addr  = addr;
    assign out_valid = beat.valid;
    assign out_chan  = beat.chan;
    assign out_data  = beat.data;
    assign out_sop   = beat.sop;
    assign out_eop   = beat.eop;

    // R5: the address holds while the strobe is first released
    p_park_addr_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_rd_n) |-> $stable(phy_addr));

    // R5 and R2: next cycle presents the following channel with strobe still high
    p_switch_addr_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_rd_n) |=> (phy_rd_n && phy_addr == next_chan($past(phy_addr))));

    // R5: reading resumes only after two idle cycles, address unchanged
    p_resume_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(phy_rd_n) |-> ($past(phy_rd_n, 2) && $stable(phy_addr)));

    // R4: an output word always follows a flagged return
    p_out_source_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(phy_avail));

endmodule

// File: tb/tb_rrx_master.sv
module tb_rrx_master;

    localparam int CLK_PERIOD = 10;
    localparam int BUDGET     = 30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  phy_addr;
    logic        phy_rd_n;
    logic        phy_avail;
    logic [31:0] phy_data;
    logic        phy_sop;
    logic        phy_eop;
    logic        out_valid;
    logic [1:0]  out_chan;
    logic [31:0] out_data;
    logic        out_sop;
    logic        out_eop;

    always #(CLK_PERIOD/2) clk = ~clk;

    rrx_master dut (
        .clk       (clk),
        .rst       (rst),
        .phy_addr  (phy_addr),
        .phy_rd_n  (phy_rd_n),
        .phy_avail (phy_avail),
        .phy_data  (phy_data),
        .phy_sop   (phy_sop),
        .phy_eop   (phy_eop),
        .out_valid (out_valid),
        .out_chan  (out_chan),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop)
    );

    int n_checks = 0;
    int n_err    = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- slave model ----------------
    int rem [4];
    int pop_seq [4];
    bit dead_pend [4];
    int plen      = 1000;
    bit dead_en   = 1'b0;
    bit stray_en  = 1'b0;
    int pop_total = 0;

    logic        s1_en = 1'b0, s1_v = 1'b0, s1_sop = 1'b0, s1_eop = 1'b0;
    logic [31:0] s1_d  = '0;
    logic        s2_en = 1'b0, s2_v = 1'b0, s2_sop = 1'b0, s2_eop = 1'b0;
    logic [31:0] s2_d  = '0;

    function automatic logic [31:0] mk_word(input int c, input int s);
        return {2'(c), 6'd0, 24'(s)};
    endfunction

    always @(posedge clk) begin
        int a;
        bit e;
        if (rst) begin
            s1_en <= 1'b0; s1_v <= 1'b0; s2_en <= 1'b0; s2_v <= 1'b0;
        end else begin
            s2_en <= s1_en; s2_v <= s1_v; s2_d <= s1_d; s2_sop <= s1_sop; s2_eop <= s1_eop;
            s1_en <= !phy_rd_n; s1_v <= 1'b0; s1_sop <= 1'b0; s1_eop <= 1'b0; s1_d <= '0;
            if (!phy_rd_n) begin
                a = int'(phy_addr);
                if (dead_en && dead_pend[a]) begin
                    dead_pend[a] = 1'b0;
                end else if (rem[a] > 0) begin
                    e = (pop_seq[a] % plen) == plen - 1;
                    s1_v   <= 1'b1;
                    s1_d   <= mk_word(a, pop_seq[a]);
                    s1_sop <= (pop_seq[a] % plen) == 0;
                    s1_eop <= e;
                    if (dead_en && e) dead_pend[a] = 1'b1;
                    pop_seq[a]++;
                    rem[a]--;
                    pop_total++;
                end
            end
        end
    end

    assign phy_avail = s2_v | (stray_en & ~s2_en);
    assign phy_data  = s2_v ? s2_d : 32'hDEAD_BEEF;
    assign phy_sop   = s2_v ? s2_sop : stray_en;
    assign phy_eop   = s2_v ? s2_eop : stray_en;

    // ---------------- visit monitor and scoreboard ----------------
    int v_chan [16];
    int v_en   [16];
    int v_pop  [16];
    int v_gap  [16];
    int v_g1   [16];
    int v_g2   [16];
    int nvis = 0, cur_en = 0, pop_start = 0, gap = 0, g1 = -1, g2 = -1;
    bit in_visit = 1'b0;
    int out_cnt [4];

    always @(negedge clk) begin
        int c;
        if (rst) begin
            in_visit = 1'b0; nvis = 0; gap = 0; g1 = -1; g2 = -1;
        end else begin
            if (!phy_rd_n) begin
                if (!in_visit) begin
                    in_visit = 1'b1; cur_en = 0; pop_start = pop_total;
                    if (nvis < 16) begin
                        v_chan[nvis] = int'(phy_addr);
                        v_gap[nvis] = gap; v_g1[nvis] = g1; v_g2[nvis] = g2;
                    end
                end
                cur_en++;
            end else begin
                if (in_visit) begin
                    if (nvis < 16) begin
                        v_en[nvis]  = cur_en;
                        v_pop[nvis] = pop_total - pop_start;
                    end
                    nvis++; in_visit = 1'b0; gap = 0;
                end
                gap++;
                if (gap == 1) g1 = int'(phy_addr);
                if (gap == 2) g2 = int'(phy_addr);
            end
            if (out_valid) begin
                c = int'(out_chan);
                check(out_data == mk_word(c, out_cnt[c]), "R9 out_data", out_data, mk_word(c, out_cnt[c]));
                check(out_sop == ((out_cnt[c] % plen) == 0), "R9 out_sop", out_sop, (out_cnt[c] % plen) == 0);
                check(out_eop == ((out_cnt[c] % plen) == plen - 1), "R9 out_eop", out_eop, (out_cnt[c] % plen) == plen - 1);
                out_cnt[c]++;
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        for (int c = 0; c < 4; c++) begin
            rem[c] = 0; pop_seq[c] = 0; dead_pend[c] = 1'b0; out_cnt[c] = 0;
        end
        dead_en = 1'b0; stray_en = 1'b0; plen = 1000;
        repeat (3) @(negedge clk);
        check(phy_rd_n == 1'b1, "R1 rd_n in reset", phy_rd_n, 1);
        check(phy_addr == 2'd0, "R1 addr in reset", phy_addr, 0);
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    endtask

    task automatic release_reset();
        rst = 1'b0;
    endtask

    task automatic wait_visits(input int n);
        while (nvis < n) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        release_reset();
        wait_visits(1);
        check(v_chan[0] == 0, "R1 first visit channel", v_chan[0], 0);
    endtask

    task automatic t_full();
        do_reset();
        for (int c = 0; c < 4; c++) rem[c] = 200;
        plen = 7;
        release_reset();
        wait_visits(8);
        for (int i = 0; i < 8; i++) begin
            check(v_chan[i] == i % 4, "R2 rotation", v_chan[i], i % 4);
            check(v_en[i] == BUDGET, "R3 strobe cycles per visit", v_en[i], BUDGET);
            check(v_pop[i] == BUDGET, "R3 words per visit", v_pop[i], BUDGET);
            if (i > 0) begin
                check(v_gap[i] == 2, "R5 idle cycles", v_gap[i], 2);
                check(v_g1[i] == v_chan[i-1], "R5 park address", v_g1[i], v_chan[i-1]);
                check(v_g2[i] == v_chan[i], "R5 switch address", v_g2[i], v_chan[i]);
            end
        end
        for (int c = 1; c < 4; c++) begin
            check(out_cnt[c] == 2 * BUDGET, "R7 trailing words forwarded", out_cnt[c], 2 * BUDGET);
        end
    endtask

    task automatic t_drain();
        int n [4];
        n[0] = 5; n[1] = 0; n[2] = 12; n[3] = 1;
        do_reset();
        for (int c = 0; c < 4; c++) rem[c] = n[c];
        release_reset();
        wait_visits(4);
        for (int i = 0; i < 4; i++) begin
            check(v_chan[i] == i, "R2 rotation drain", v_chan[i], i);
            check(v_en[i] == n[i] + 3, "R6 dry visit length", v_en[i], n[i] + 3);
            check(v_pop[i] == n[i], "R6 dry visit words", v_pop[i], n[i]);
            check(out_cnt[i] == n[i], "R6 words forwarded", out_cnt[i], n[i]);
        end
    endtask

    task automatic t_dead();
        int sum [4];
        do_reset();
        for (int c = 0; c < 4; c++) begin rem[c] = 90; sum[c] = 0; end
        plen = 3; dead_en = 1'b1;
        release_reset();
        wait_visits(8);
        for (int i = 0; i < 8; i++) begin
            check(v_pop[i] <= BUDGET, "R3 budget with gaps", v_pop[i], BUDGET);
            check(v_pop[i] >= BUDGET - 2, "R8 gap not taken as dry", v_pop[i], BUDGET - 2);
            check(v_en[i] > v_pop[i], "R8 gap not counted", v_en[i], v_pop[i] + 1);
            sum[v_chan[i]] += v_pop[i];
        end
        for (int c = 0; c < 4; c++) begin
            check(out_cnt[c] == sum[c], "R8 words forwarded with gaps", out_cnt[c], sum[c]);
        end
    endtask

    task automatic t_stray();
        do_reset();
        for (int c = 0; c < 4; c++) rem[c] = 3;
        stray_en = 1'b1;
        release_reset();
        wait_visits(4);
        for (int i = 0; i < 4; i++) begin
            check(v_en[i] == 6, "R4 visit length with stray flag", v_en[i], 6);
            check(out_cnt[i] == 3, "R4 stray flag ignored", out_cnt[i], 3);
        end
    endtask

    initial begin
        t_reset();
        t_full();
        t_drain();
        t_dead();
        t_stray();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule